// File: doc/BRIEF.md
# SPI Flash Fast-Read Slave Responder

This block plays the device side of a serial flash on an SPI bus, for the fast-read command only. It runs on a local system clock and oversamples chip select, serial clock and serial data in. A frame opens when chip select falls. The master then clocks in three parts on rising serial-clock edges: an opcode byte, a 24-bit byte address with the most significant bit first, and one byte of don't-care filler. After that, the block returns bytes from a small internal array on its data-out pin. It drives a new bit after every falling serial-clock edge and moves the address on after each complete byte.

Reading may start anywhere in the array. When the counter leaves the last location it wraps to location zero, so a read keeps going until chip select rises. Chip select may rise at any moment, even partway through a byte. That ends the frame and turns the output off. The frame is dropped silently in two cases: the opcode is not fast-read, or the busy input shows an erase, program or write cycle in progress. The array depth is a parameter. A preload port lets a testbench fill the array.

Top module: `spi_fastread_resp`

## Requirements
- R1: While chip select is high, and after reset, `spi_miso_oe` is 0, and `spi_miso` is 0 whenever `spi_miso_oe` is 0.
- R2: The frame header is 40 bits, each sampled on a rising serial-clock edge: opcode 8'h0B, then address bits 23 down to 0, then 8 filler bits. `spi_miso_oe` stays 0 for all 40 header bits.
- R3: The first data bit (bit 7 of the addressed byte) is driven after the first falling serial-clock edge that follows the last filler bit. Each later falling edge drives the next lower bit, so bytes go out MSB first and the output changes only on a falling edge or on frame end.
- R4: Once a byte has been fully shifted out, the next byte comes from the address one higher, for as long as chip select stays low.
- R5: After the byte at location DEPTH-1, the next byte comes from location 0.
- R6: The array location is the received address modulo DEPTH, where DEPTH is a power of two no larger than 2^20. Address bits 23..20 therefore never affect the data.
- R7: Raising chip select at any point, including partway through a byte, brings `spi_miso_oe` and `spi_miso` to 0 within 4 system clocks. The next frame starts again from its opcode.
- R8: If `busy_i` is 1 when the eighth opcode bit is sampled, the frame is ignored: `spi_miso_oe` stays 0 until chip select rises.
- R9: An opcode other than 8'h0B makes the block ignore the rest of the frame, so `spi_miso_oe` stays 0 until chip select rises.
- R10: When `pl_we` is 1 at a rising `clk` edge, `pl_data` is written to location `pl_addr`, and later reads return it.
- R11: Frames work with the serial clock idling low (mode 0) and with it idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, must run well above the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data in |
| busy_i | input | 1 | High while an erase, program or write cycle runs |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | $clog2(DEPTH) | Preload location |
| pl_data | input | 8 | Preload byte |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for serial data out (0 = high impedance) |

## Verification
The hardest case to reach from the pins is a read that runs past the top of the array and then gets cut off partway through a byte. To hit the wrap at all, a frame has to start within a few bytes of DEPTH-1 and last long enough to cross it. The bench uses a 64-byte array so directed frames can start at 62 and random frames often cross the top. A separate directed frame raises chip select after three bits of a byte, checks that the output goes quiet, and then runs a normal frame straight after it to show nothing was left over.

// File: rtl/spi_fr_pkg.sv
package spi_fr_pkg;

    localparam logic [7:0] FR_OPCODE = 8'h0B;

    // frame phases of the responder
    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DUMMY = 3'd2,
        PH_DATA  = 3'd3,
        PH_SKIP  = 3'd4
    } fr_phase_e;

    // bit positions inside the 40-bit header where a phase ends
    localparam logic [5:0] CMD_LAST   = 6'd7;
    localparam logic [5:0] ADDR_LAST  = 6'd31;
    localparam logic [5:0] DUMMY_LAST = 6'd39;

endpackage

// File: rtl/spi_fr_sync.sv
// Multi-stage synchroniser for a small vector of asynchronous pins.
module spi_fr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_fr_edge.sv
// Turns a synchronised level into one-cycle rise and fall pulses.
module spi_fr_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise = din & ~prev_q;
    assign fall = ~din & prev_q;

endmodule

// File: rtl/spi_fr_mem.sv
// Byte array with a preload write port and an asynchronous read port.
module spi_fr_mem #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/spi_fr_ctrl.sv
// Frame sequencer: header decode, address counter and serial output.
module spi_fr_ctrl
    import spi_fr_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH),
    // only the opcode and the low address bits ever need to be held
    localparam int SH_W  = (IDX_W - 1 > 7) ? IDX_W - 1 : 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_hi,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             mosi,
    input  logic             busy,
    input  logic [7:0]       rdata,
    output logic [IDX_W-1:0] raddr,
    output logic             miso,
    output logic             miso_oe,
    output fr_phase_e        phase
);

    typedef struct packed {
        fr_phase_e        ph;
        logic [5:0]       cnt;
        logic [SH_W-1:0]  sh;
        logic [IDX_W-1:0] idx;
        logic [2:0]       bpos;
        logic [6:0]       obuf;
        logic             miso;
        logic             oe;
    } ctrl_t;

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);

    ctrl_t st_d, st_q;
    logic [7:0]       opcode_w;
    logic [IDX_W-1:0] start_idx_w;

    // the bit being sampled completes the opcode / address
    assign opcode_w    = {st_q.sh[6:0], mosi};
    // address bits above the array index (including A23..A20) are dropped
    assign start_idx_w = {st_q.sh[IDX_W-2:0], mosi};

    always_comb begin
        st_d = st_q;
        if (cs_hi) begin
            st_d.ph   = PH_CMD;
            st_d.cnt  = '0;
            st_d.bpos = 3'd7;
            st_d.miso = 1'b0;
            st_d.oe   = 1'b0;
        end else begin
            if (sclk_rise) begin
                unique case (st_q.ph)
                    PH_CMD, PH_ADDR, PH_DUMMY: begin
                        st_d.sh  = {st_q.sh[SH_W-2:0], mosi};
                        st_d.cnt = st_q.cnt + 6'd1;
                        if (st_q.cnt == CMD_LAST) begin
                            if (busy || (opcode_w != FR_OPCODE)) begin
                                st_d.ph = PH_SKIP;
                            end else begin
                                st_d.ph = PH_ADDR;
                            end
                        end else if (st_q.cnt == ADDR_LAST) begin
                            st_d.ph  = PH_DUMMY;
                            st_d.idx = start_idx_w;
                        end else if (st_q.cnt == DUMMY_LAST) begin
                            st_d.ph   = PH_DATA;
                            st_d.bpos = 3'd7;
                        end
                    end
                    default: begin
                        // data and skip phases ignore serial input
                    end
                endcase
            end
            if (sclk_fall && (st_q.ph == PH_DATA)) begin
                st_d.oe = 1'b1;
                if (st_q.bpos == 3'd7) begin
                    // capture the whole byte so later preloads cannot tear it
                    st_d.miso = rdata[7];
                    st_d.obuf = rdata[6:0];
                end else begin
                    st_d.miso = st_q.obuf[6];
                    st_d.obuf = {st_q.obuf[5:0], 1'b0};
                end
                if (st_q.bpos == 3'd0) begin
                    st_d.idx = (st_q.idx == TOP_IDX) ? '0 : st_q.idx + IDX_W'(1);
                end
                st_d.bpos = st_q.bpos - 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_CMD;
            st_q.bpos <= 3'd7;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr   = st_q.idx;
    assign miso    = st_q.miso;
    assign miso_oe = st_q.oe;
    assign phase   = st_q.ph;

endmodule

// File: rtl/spi_fastread_resp.sv
// Top level: fast-read responder of a serial flash device.
module spi_fastread_resp
    import spi_fr_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_cs_n,
    input  logic             spi_sclk,
    input  logic             spi_mosi,
    input  logic             busy_i,
    input  logic             pl_we,
    input  logic [IDX_W-1:0] pl_addr,
    input  logic [7:0]       pl_data,
    output logic             spi_miso,
    output logic             spi_miso_oe
);

    logic [2:0]       pins_s;
    logic             cs_s, sclk_s, mosi_s;
    logic             sclk_rise, sclk_fall;
    logic [7:0]       mem_rdata;
    logic [IDX_W-1:0] mem_raddr;
    fr_phase_e        ctrl_ph;

    spi_fr_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_sclk, spi_mosi}),
        .dout  (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[0];

    spi_fr_edge #(
        .RST_VAL (1'b0)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sclk_s),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    spi_fr_mem #(
        .DEPTH (DEPTH)
    ) u_mem (
        .clk   (clk),
        .we    (pl_we),
        .waddr (pl_addr),
        .wdata (pl_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    spi_fr_ctrl #(
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_hi     (cs_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi      (mosi_s),
        .busy      (busy_i),
        .rdata     (mem_rdata),
        .raddr     (mem_raddr),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe),
        .phase     (ctrl_ph)
    );

endmodule

// File: rtl/spi_fr_chk.sv
module spi_fr_chk
    import spi_fr_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input logic      miso,
    input logic      oe,
    input logic      sclk_fall,
    input logic      cs_hi,
    input fr_phase_e ph
);

    AST_QUIET_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_DATA) |-> !oe); // R2

    AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !miso); // R1

    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(sclk_fall || cs_hi)); // R3

    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !oe); // R7

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_SKIP) |=> !oe); // R8

endmodule

bind spi_fastread_resp spi_fr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (spi_cs_n),
    .miso      (spi_miso),
    .oe        (spi_miso_oe),
    .sclk_fall (sclk_fall),
    .cs_hi     (cs_s),
    .ph        (ctrl_ph)
);

// File: tb/sim_spi_fastread_resp.sv
`timescale 1ns/1ps
module sim_spi_fastread_resp;

    localparam int DEPTH = 64;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int HALF  = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             spi_cs_n = 1'b1;
    logic             spi_sclk = 1'b0;
    logic             spi_mosi = 1'b0;
    logic             busy_i = 1'b0;
    logic             pl_we = 1'b0;
    logic [IDX_W-1:0] pl_addr = '0;
    logic [7:0]       pl_data = '0;
    logic             spi_miso;
    logic             spi_miso_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mem [DEPTH];

    always #2.5 clk = ~clk;

    spi_fastread_resp #(.DEPTH(DEPTH)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sclk    (spi_sclk),
        .spi_mosi    (spi_mosi),
        .busy_i      (busy_i),
        .pl_we       (pl_we),
        .pl_addr     (pl_addr),
        .pl_data     (pl_data),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int loc_of(input logic [23:0] a, input int k);
        return (int'(a % DEPTH) + k) % DEPTH;
    endfunction

    task automatic write_byte(input int a, input logic [7:0] v);
        @(negedge clk);
        pl_we = 1'b1; pl_addr = IDX_W'(a); pl_data = v;
        @(negedge clk);
        pl_we = 1'b0;
        exp_mem[a] = v;
    endtask

    task automatic spi_bit(input logic b, output logic o, output logic oe);
        @(negedge clk);
        spi_sclk = 1'b0; spi_mosi = b;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        o = spi_miso; oe = spi_miso_oe;
    endtask

    // abort_bits < 0: run nbytes complete bytes; otherwise raise cs after that many data bits
    task automatic frame(input logic [7:0] op, input logic [23:0] addr, input int nbytes,
                         input bit mode3, input bit busy_v, input int abort_bits,
                         input string dtag);
        logic o, oe;
        logic [7:0] got;
        bit quiet, accept, off_ok;
        int nbits;
        accept = (op == 8'h0B) && !busy_v;
        spi_sclk = mode3;
        busy_i = busy_v;
        repeat (3) @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (3) @(negedge clk);
        quiet = 1'b1;
        for (int i = 0; i < 40; i++) begin
            logic b;
            if (i < 8)       b = op[7-i];
            else if (i < 32) b = addr[31-i];
            else             b = 1'($urandom);
            spi_bit(b, o, oe);
            if (oe) quiet = 1'b0;
        end
        chk(quiet, "R2 header keeps output off", 0, 0);
        nbits = (abort_bits >= 0) ? abort_bits : nbytes * 8;
        got = '0;
        off_ok = 1'b1;
        for (int j = 0; j < nbits; j++) begin
            spi_bit(1'($urandom), o, oe);
            got = {got[6:0], o};
            if (accept) begin
                if (!oe) off_ok = 1'b0;
                if ((j % 8) == 7) begin
                    int l;
                    l = loc_of(addr, j / 8);
                    chk(got == exp_mem[l], dtag, got, exp_mem[l]);
                end
            end else if (oe) begin
                off_ok = 1'b0;
            end
        end
        if (nbits > 0) begin
            if (accept) chk(off_ok, "R3 output enabled in data", 0, 1);
            else if (busy_v) chk(off_ok, "R8 busy frame stays silent", 1, 0);
            else chk(off_ok, "R9 foreign opcode stays silent", 1, 0);
        end
        @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!spi_miso_oe && !spi_miso, "R7 release quiets output",
            {spi_miso_oe, spi_miso}, 0);
        if (!mode3) spi_sclk = 1'b0;
        busy_i = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!spi_miso_oe && !spi_miso, "R1 reset state", {spi_miso_oe, spi_miso}, 0);

        for (int a = 0; a < DEPTH; a++) write_byte(a, 8'($urandom));
        write_byte(0, 8'hA5);
        write_byte(1, 8'h3C);

        // R3/R4: basic read from location 0, MSB first
        frame(8'h0B, 24'h000000, 3, 1'b0, 1'b0, -1, "R3 R4 byte sequence");
        // R11: mode 3
        frame(8'h0B, 24'h000010, 2, 1'b1, 1'b0, -1, "R11 mode 3 data");
        // R5: wrap from the top
        frame(8'h0B, 24'(DEPTH - 2), 4, 1'b0, 1'b0, -1, "R5 wrap to zero");
        // R6: high address bits ignored
        frame(8'h0B, 24'hF00000 | 24'(DEPTH * 5 + 3), 2, 1'b0, 1'b0, -1, "R6 high bits ignored");
        // R8: busy rejects
        frame(8'h0B, 24'h000004, 2, 1'b0, 1'b1, -1, "R8 busy");
        // R9: other opcode
        frame(8'h03, 24'h000004, 2, 1'b1, 1'b0, -1, "R9 other opcode");
        // R7: abort partway through the second byte, then a clean frame
        frame(8'h0B, 24'h000008, 2, 1'b0, 1'b0, 11, "R7 aborted frame data");
        frame(8'h0B, 24'h000008, 2, 1'b0, 1'b0, -1, "R7 frame after abort");
        // R10: preload rewrite is visible
        write_byte(20, 8'h5A);
        frame(8'h0B, 24'd20, 1, 1'b1, 1'b0, -1, "R10 preload visible");

        // constrained random frames
        for (int n = 0; n < 18; n++) begin
            logic [7:0] op;
            bit b;
            op = (($urandom % 6) == 0) ? 8'($urandom) : 8'h0B;
            b  = (($urandom % 7) == 0);
            frame(op, 24'($urandom), 1 + int'($urandom % 5), 1'($urandom), b,
                  -1, "R4 R5 random stream");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule